// File: doc/BRIEF.md
# Bus Request-Phase Packet Generator

This block forms the request phase of a transaction for the agent that starts it on a shared processor bus. A transaction descriptor is handed over through a valid/ready handshake. The descriptor holds a 36-bit physical address or I/O port number, a 5-bit transaction kind, a 3-bit memory caching type, a 2-bit length code and an 8-bit byte-enable mask. The block checks the descriptor and holds it. It then waits until the external arbiter grants the bus. After the grant it drives two packets, one after the other, on a shared set of 33 address pins and 5 request pins.

The first packet carries the 8-byte-aligned address, which is bits 35..3 because the low three bits are always zero. It also carries the transaction kind and raises a start strobe. The second packet follows on the very next clock on the same pins. In place of the address it carries the caching type, the length code and the byte lanes. A descriptor that breaks the caching rules is refused. The block reports it with a one-cycle error pulse and puts nothing on the bus. Arbitration, snooping, responses and the data phase are handled outside this block.

Top module: `bus_req_gen`

## Requirements
- R1: `in_ready` is high only while the block is idle. A descriptor is taken on a clock where `in_valid` and `in_ready` are both high. After a descriptor is taken, `in_ready` stays low through the second packet's cycle and returns high on the next cycle.
- R2: After a descriptor is taken, nothing appears on the pins until `bus_grant` is sampled high. The first packet is driven in the cycle after that sample. A grant that arrives while the block is idle has no effect.
- R3: In the first-packet cycle, `pkt_start` is 1, `pin_addr` equals descriptor address bits 35..3 (this holds for memory addresses and I/O port numbers alike), and `pin_req` equals the 5-bit kind.
- R4: In the cycle right after the first packet, the second packet is driven and `pkt_start` is 0. `pin_addr[2:0]` holds the caching type, `pin_addr[4:3]` holds the length code and `pin_addr[12:5]` holds the byte lanes. All other `pin_addr` bits and `pin_req` are 0.
- R5: Outside the two packet cycles, `pin_addr`, `pin_req` and `pkt_start` are all 0.
- R6: The legal caching types are 000 (uncacheable), 001 (write-combining), 100 (write-through), 110 (write-protected) and 111 (write-back). Any other type is refused with error code 1.
- R7: A write-back descriptor must have address bits 5..0 equal to zero and length code 11. Otherwise it is refused with error code 2.
- R8: For an uncacheable descriptor, the byte lanes are the mask shifted left by address bits 2..0. A zero mask is refused with error code 3. A mask whose shifted bits would pass lane 7 is also refused with error code 3. For every other caching type, the mask is passed through unchanged.
- R9: A refused descriptor still completes its handshake. One cycle later, `err_valid` pulses for a single cycle with `err_code`. No packet follows, and `in_ready` stays high.
- R10: After reset, the block is idle: `in_ready` is 1, `err_valid` is 0 and all pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Block can take a descriptor |
| in_addr | input | 36 | Physical address or I/O port |
| in_kind | input | 5 | Transaction kind |
| in_mtype | input | 3 | Memory caching type |
| in_len | input | 2 | Length code |
| in_be | input | 8 | Byte-enable mask |
| bus_grant | input | 1 | Arbitration won |
| pkt_start | output | 1 | High in the first-packet cycle |
| pin_addr | output | 33 | Shared address pins |
| pin_req | output | 5 | Shared request pins |
| err_valid | output | 1 | Refused-descriptor pulse |
| err_code | output | 2 | Reason for refusal |

## Verification
Two functions can fall in the same clock. The first case is a grant while the block is idle, combined with acceptance of a new descriptor. The bench holds `bus_grant` high across the end of a second packet, while the next descriptor is offered at once. That descriptor must still wait for a grant sampled after its acceptance. The second case is a refusal while the grant is high. The bench drives a grant while an illegal descriptor is handed over. A behavioural model compares every pin on every clock, so any early start strobe or any packet after a refusal is reported.

// File: rtl/bpkt_pkg.sv
package bpkt_pkg;
    localparam int ADDR_W     = 36;
    localparam int CHUNK_LOG2 = 3;
    localparam int LINE_LOG2  = 6;
    localparam int PIN_W      = ADDR_W - CHUNK_LOG2;
    localparam int KIND_W     = 5;
    localparam int MT_W       = 3;
    localparam int LEN_W      = 2;
    localparam int BE_W       = 1 << CHUNK_LOG2;
    localparam int PKB_W      = MT_W + LEN_W + BE_W;

    localparam logic [MT_W-1:0]  MT_UC = 3'b000;
    localparam logic [MT_W-1:0]  MT_WC = 3'b001;
    localparam logic [MT_W-1:0]  MT_WT = 3'b100;
    localparam logic [MT_W-1:0]  MT_WP = 3'b110;
    localparam logic [MT_W-1:0]  MT_WB = 3'b111;
    localparam logic [LEN_W-1:0] LEN_LINE = 2'b11;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_ATTR = 2'd1,
        ERR_WB   = 2'd2,
        ERR_UC   = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HOLD,
        PH_PKTA,
        PH_PKTB
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [KIND_W-1:0] kind;
        logic [MT_W-1:0]   mtype;
        logic [LEN_W-1:0]  len;
        logic [BE_W-1:0]   be;
    } desc_t;

    function automatic logic mtype_known(input logic [MT_W-1:0] mt);
        return (mt == MT_UC) || (mt == MT_WC) || (mt == MT_WT) ||
               (mt == MT_WP) || (mt == MT_WB);
    endfunction

    function automatic logic [2*BE_W-1:0] lane_spread(input logic [BE_W-1:0] be,
                                                      input logic [CHUNK_LOG2-1:0] off);
        logic [2*BE_W-1:0] wide;
        wide = {{BE_W{1'b0}}, be};
        return wide << off;
    endfunction
endpackage

// File: rtl/bpkt_check.sv
module bpkt_check
    import bpkt_pkg::*;
(
    input  desc_t           desc,
    output err_e            code,
    output logic [BE_W-1:0] lanes
);
    logic [2*BE_W-1:0] spread;
    logic              wb_bad;
    logic              uc_bad;

    always_comb begin
        spread = lane_spread(desc.be, desc.addr[CHUNK_LOG2-1:0]);
        wb_bad = (desc.addr[LINE_LOG2-1:0] != '0) || (desc.len != LEN_LINE);
        uc_bad = (desc.be == '0) || (spread[2*BE_W-1:BE_W] != '0);
        lanes  = (desc.mtype == MT_UC) ? spread[BE_W-1:0] : desc.be;
        if (!mtype_known(desc.mtype))
            code = ERR_ATTR;
        else if (desc.mtype == MT_WB && wb_bad)
            code = ERR_WB;
        else if (desc.mtype == MT_UC && uc_bad)
            code = ERR_UC;
        else
            code = ERR_NONE;
    end
endmodule

// File: rtl/bpkt_seq.sv
module bpkt_seq
    import bpkt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  err_e   chk_code,
    input  logic   bus_grant,
    output logic   in_ready,
    output logic   load,
    output phase_e phase,
    output logic   err_valid,
    output err_e   err_code
);
    phase_e phase_q;
    logic   take;

    assign in_ready = (phase_q == PH_IDLE);
    assign take     = in_valid && in_ready;
    assign load     = take && (chk_code == ERR_NONE);
    assign phase    = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_valid <= take && (chk_code != ERR_NONE);
            err_code  <= take ? chk_code : ERR_NONE;
            unique case (phase_q)
                PH_IDLE: if (load) phase_q <= PH_HOLD;
                PH_HOLD: if (bus_grant) phase_q <= PH_PKTA;
                PH_PKTA: phase_q <= PH_PKTB;
                PH_PKTB: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bpkt_pins.sv
module bpkt_pins
    import bpkt_pkg::*;
(
    input  phase_e            phase,
    input  desc_t             held,
    input  logic [BE_W-1:0]   held_lanes,
    output logic              pkt_start,
    output logic [PIN_W-1:0]  pin_addr,
    output logic [KIND_W-1:0] pin_req
);
    logic [PKB_W-1:0] pkt_b;

    assign pkt_b = {held_lanes, held.len, held.mtype};

    always_comb begin
        pkt_start = 1'b0;
        pin_addr  = '0;
        pin_req   = '0;
        case (phase)
            PH_PKTA: begin
                pkt_start = 1'b1;
                pin_addr  = held.addr[ADDR_W-1:CHUNK_LOG2];
                pin_req   = held.kind;
            end
            PH_PKTB: pin_addr = {{(PIN_W-PKB_W){1'b0}}, pkt_b};
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_req_gen.sv
module bus_req_gen
    import bpkt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [KIND_W-1:0]   in_kind,
    input  logic [MT_W-1:0]     in_mtype,
    input  logic [LEN_W-1:0]    in_len,
    input  logic [BE_W-1:0]     in_be,
    input  logic                bus_grant,
    output logic                pkt_start,
    output logic [PIN_W-1:0]    pin_addr,
    output logic [KIND_W-1:0]   pin_req,
    output logic                err_valid,
    output logic [1:0]          err_code
);
    desc_t           desc_in;
    desc_t           held_q;
    logic [BE_W-1:0] lanes_in;
    logic [BE_W-1:0] lanes_q;
    err_e            chk_code;
    err_e            err_code_e;
    logic            load;
    phase_e          phase;

    assign desc_in = '{addr: in_addr, kind: in_kind, mtype: in_mtype,
                       len: in_len, be: in_be};

    bpkt_check u_check (
        .desc  (desc_in),
        .code  (chk_code),
        .lanes (lanes_in)
    );

    bpkt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .chk_code  (chk_code),
        .bus_grant (bus_grant),
        .in_ready  (in_ready),
        .load      (load),
        .phase     (phase),
        .err_valid (err_valid),
        .err_code  (err_code_e)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            lanes_q <= '0;
        end else if (load) begin
            held_q  <= desc_in;
            lanes_q <= lanes_in;
        end
    end

    bpkt_pins u_pins (
        .phase      (phase),
        .held       (held_q),
        .held_lanes (lanes_q),
        .pkt_start  (pkt_start),
        .pin_addr   (pin_addr),
        .pin_req    (pin_req)
    );

    assign err_code = err_code_e;
endmodule

// File: rtl/bus_req_gen_sva.sv
module bus_req_gen_sva (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        bus_grant,
    input logic        pkt_start,
    input logic [32:0] pin_addr,
    input logic [4:0]  pin_req,
    input logic        err_valid
);
    AST_START_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        pkt_start |-> $past(bus_grant)) else $error("start without grant"); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        pkt_start |-> !in_ready) else $error("ready during packet A"); // R1
    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        pkt_start |=> !pkt_start && !in_ready && pin_req == 5'd0) else $error("packet B malformed"); // R4
    AST_PKTB_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        pkt_start |=> pin_addr[32:13] == 20'd0) else $error("packet B upper pins"); // R4
    AST_WB_LINE_LEN: assert property (@(posedge clk) disable iff (rst)
        ($past(pkt_start) && pin_addr[2:0] == 3'b111) |-> pin_addr[4:3] == 2'b11) else $error("wb length"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (pin_addr == 33'd0 && pin_req == 5'd0 && !pkt_start)) else $error("idle pins"); // R5
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ($past(in_valid && in_ready) && in_ready && !pkt_start)) else $error("error pulse"); // R9
endmodule

bind bus_req_gen bus_req_gen_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .bus_grant (bus_grant),
    .pkt_start (pkt_start),
    .pin_addr  (pin_addr),
    .pin_req   (pin_req),
    .err_valid (err_valid)
);

// File: tb/bus_req_gen_tb_top.sv
`timescale 1ns/1ps
module bus_req_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [35:0] in_addr = '0;
    logic [4:0]  in_kind = '0;
    logic [2:0]  in_mtype = '0;
    logic [1:0]  in_len = '0;
    logic [7:0]  in_be = '0;
    logic        bus_grant = 1'b0;
    logic        in_ready, pkt_start, err_valid;
    logic [32:0] pin_addr;
    logic [4:0]  pin_req;
    logic [1:0]  err_code;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    bit live = 0;

    always #2 clk = ~clk;

    bus_req_gen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_kind(in_kind), .in_mtype(in_mtype),
        .in_len(in_len), .in_be(in_be), .bus_grant(bus_grant),
        .pkt_start(pkt_start), .pin_addr(pin_addr), .pin_req(pin_req),
        .err_valid(err_valid), .err_code(err_code)
    );

    typedef struct {
        logic [35:0] addr;
        logic [4:0]  kind;
        logic [2:0]  mt;
        logic [1:0]  len;
        logic [7:0]  lanes;
    } ref_t;

    ref_t q[$];
    int   m_stage = 0;
    bit   m_err = 0;
    int   m_code = 0;

    function automatic int ref_verdict(input logic [35:0] a, input logic [2:0] mt,
                                       input logic [1:0] len, input logic [7:0] be,
                                       output logic [7:0] lanes);
        int off;
        lanes = be;
        if (!(mt inside {3'd0, 3'd1, 3'd4, 3'd6, 3'd7})) return 1;
        if (mt == 3'd7) return (a % 64 != 0 || len != 2'd3) ? 2 : 0;
        if (mt == 3'd0) begin
            off = int'(a % 8);
            lanes = 8'd0;
            if (be == 8'd0) return 3;
            for (int i = 0; i < 8; i++) begin
                if (be[i]) begin
                    if (i + off > 7) return 3;
                    lanes[i + off] = 1'b1;
                end
            end
        end
        return 0;
    endfunction

    // reference model: advances on each rising edge from the inputs held there
    always @(posedge clk) begin
        logic [7:0] ln;
        int v;
        if (rst) begin
            m_stage = 0; m_err = 0; q.delete();
        end else begin
            m_err = 0;
            if (m_stage == 0) begin
                if (in_valid) begin
                    v = ref_verdict(in_addr, in_mtype, in_len, in_be, ln);
                    if (v != 0) begin m_err = 1; m_code = v; end
                    else begin
                        q.push_back('{addr: in_addr, kind: in_kind, mt: in_mtype, len: in_len, lanes: ln});
                        m_stage = 1;
                    end
                end
            end else if (m_stage == 1) begin
                if (bus_grant) m_stage = 2;
            end else if (m_stage == 2) m_stage = 3;
            else begin m_stage = 0; void'(q.pop_front()); end
        end
        live = 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare every pin on every falling edge
    always @(negedge clk) begin
        logic [32:0] ea;
        logic [4:0]  er;
        if (live && !done) begin
            ea = '0; er = '0;
            if (m_stage == 2) begin ea = q[0].addr[35:3]; er = q[0].kind; end
            if (m_stage == 3) ea = {20'd0, q[0].lanes, q[0].len, q[0].mt};
            chk(rst ? "R10 ready" : "R1 ready", 64'(in_ready), 64'(m_stage == 0));
            chk("R2 start", 64'(pkt_start), 64'(m_stage == 2));
            chk(m_stage == 2 ? "R3 addr" : (m_stage == 3 ? "R4 addr" : "R5 addr"), 64'(pin_addr), 64'(ea));
            chk(m_stage == 2 ? "R3 req" : "R5 req", 64'(pin_req), 64'(er));
            chk("R9 err_valid", 64'(err_valid), 64'(m_err));
            if (m_err) chk("R9 err_code", 64'(err_code), 64'(m_code));
        end
    end

    task automatic offer(input logic [35:0] a, input logic [4:0] k, input logic [2:0] mt,
                         input logic [1:0] len, input logic [7:0] be, input int gdelay);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_addr = a; in_kind = k; in_mtype = mt; in_len = len; in_be = be;
        @(negedge clk);
        in_valid = 0;
        if (gdelay >= 0) begin
            repeat (gdelay) @(negedge clk);
            bus_grant = 1;
            @(negedge clk);
            bus_grant = 0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: idle after reset, grant while idle ignored (R2)
        bus_grant = 1;
        repeat (3) @(negedge clk);
        bus_grant = 0;
        // R3 R4 R7: legal write-back with delayed grant
        offer(36'h8_1234_5640, 5'h06, 3'b111, 2'b11, 8'hFF, 3);
        // R7: misaligned write-back, bad length
        offer(36'h0_0000_0048, 5'h06, 3'b111, 2'b11, 8'hFF, -1);
        offer(36'h0_0000_0040, 5'h06, 3'b111, 2'b01, 8'hFF, -1);
        // R6: illegal types, grant held high during refusal (R9)
        bus_grant = 1;
        offer(36'h0_0000_0000, 5'h02, 3'b010, 2'b00, 8'h01, -1);
        bus_grant = 0;
        offer(36'h0_0000_0000, 5'h02, 3'b101, 2'b00, 8'h01, -1);
        // R8: uncacheable single byte at offset 5, crossing, zero mask
        offer(36'hF_FFFF_FFFD, 5'h0A, 3'b000, 2'b00, 8'h01, 1);
        offer(36'h0_0000_1006, 5'h0A, 3'b000, 2'b00, 8'h07, -1);
        offer(36'h0_0000_1000, 5'h0A, 3'b000, 2'b00, 8'h00, -1);
        offer(36'h0_0000_1004, 5'h0A, 3'b000, 2'b00, 8'h0F, 0);
        // R6: other legal types pass mask unchanged
        offer(36'h1_0000_0008, 5'h11, 3'b001, 2'b10, 8'hF0, 2);
        offer(36'h2_0000_0010, 5'h12, 3'b100, 2'b01, 8'h3C, 0);
        offer(36'h3_0000_0018, 5'h13, 3'b110, 2'b00, 8'h81, 5);
        // R3: I/O port number on address pins
        offer(36'h0_0000_03F8, 5'h1F, 3'b000, 2'b00, 8'h01, 1);
        // R1 R2: grant held high across back-to-back descriptors
        bus_grant = 1;
        for (int n = 0; n < 3; n++)
            offer(36'h0_0001_0000 + 36'(n * 64), 5'(n + 1), 3'b111, 2'b11, 8'hFF, -1);
        bus_grant = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule